// File: doc/BRIEF.md
# Serial port interrupt arbiter

This block holds the interrupt state of a classic serial port. It keeps four pending flags: line-condition, receive-ready, transmit-empty and modem-change. It masks them with a 4-bit enable register and selects the most urgent enabled flag. From that choice it drives an identification byte and the interrupt request line.

The surrounding register-access logic supplies one-cycle set and clear pulses for each flag, a write strobe with data for the enable register, and a read strobe for the identification byte. It also supplies two level inputs: the modem-control output-gate bit and the FIFO-enable bit. The identification byte and the request line are decoded without a register from the flag and enable registers. They therefore change in the cycle after the pulse that altered the state.

Top module: `sio_irq_arbiter`

## Requirements
- R1: Flag and enable-bit positions are: bit 0 receive-ready, bit 1 transmit-empty, bit 2 line-condition, bit 3 modem-change. When more than one enabled flag is pending, the choice runs from highest to lowest as line-condition, receive-ready, transmit-empty, modem-change.
- R2: `id_value[3:0]` shows the selected source as a code: 4'h6 for line-condition, 4'h4 for receive-ready, 4'h2 for transmit-empty, 4'h0 for modem-change.
- R3: When no pending flag is enabled, `id_value[3:0]` is 4'h1 and `irq` is low.
- R4: `irq` is high only when some enabled flag is pending and `out_gate` is high.
- R5: A write to the enable register keeps only bits 3:0 of `en_wdata`. `en_value` shows the stored bits in the cycle after the write.
- R6: An `id_rd` pulse while `id_value[3:0]` is 4'h2 clears the transmit-empty flag. An `id_rd` pulse while any other code is shown leaves that flag pending.
- R7: `id_value[7:6]` read 2'b11 while `fifo_on` is high and 2'b00 otherwise. `id_value[5:4]` are always zero.
- R8: After reset, the enable register and all four flags are clear, so `id_value` is 8'h01 and `irq` is low.
- R9: A set pulse and a clear pulse for the same flag in the same cycle, including the transmit-empty clear caused by `id_rd`, leave that flag set.
- R10: A set or clear pulse changes `id_value` and `irq` in the next cycle.
- R11: A flag stays pending while it is masked. Enabling it later raises the interrupt without a new set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 4 | Per-flag set pulses (bit order as in R1) |
| src_clr | input | 4 | Per-flag clear pulses |
| en_wr | input | 1 | Enable-register write strobe |
| en_wdata | input | 8 | Enable-register write data |
| id_rd | input | 1 | Identification-byte read strobe |
| out_gate | input | 1 | Modem-control gate for the request line |
| fifo_on | input | 1 | FIFO-enable bit, forces id bits 7:6 |
| en_value | output | 4 | Stored enable mask |
| id_value | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every enable mask against every pending pattern, with the gate both open and closed and the FIFO bit toggling. This catches a swapped priority level or a wrong code, which would give the wrong byte for some mask/pattern pair, and an ungated request line, which would raise `irq` with the gate shut. Directed sequences target the read-to-clear rule. They read while a higher-priority flag hides transmit-empty, and a design that cleared unconditionally would lose that flag. They also drive set and clear for the same flag in one cycle, where a clear-wins design would drop the flag. Writes with the upper enable bits set expose a design that stores all eight bits. Pending-but-masked flags are checked to rise when unmasked.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned IDX_RX = 0;
  localparam int unsigned IDX_TX = 1;
  localparam int unsigned IDX_LN = 2;
  localparam int unsigned IDX_MD = 3;

  localparam logic [3:0] CODE_LN   = 4'h6;
  localparam logic [3:0] CODE_RX   = 4'h4;
  localparam logic [3:0] CODE_TX   = 4'h2;
  localparam logic [3:0] CODE_MD   = 4'h0;
  localparam logic [3:0] CODE_NONE = 4'h1;
endpackage

// File: rtl/sio_irq_enreg.sv
module sio_irq_enreg
  import sio_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   en_o
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  assign en_o = en_q;

  AST_EN_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> en_q == NSRC'($past(wdata_i) & DATA_W'((1 << NSRC) - 1))); // R5
endmodule

// File: rtl/sio_irq_flags.sv
module sio_irq_flags
  import sio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            tx_ack_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] clr_all;
  logic            upd;

  always_comb begin
    clr_all         = clr_i;
    clr_all[IDX_TX] = clr_i[IDX_TX] | tx_ack_i;
    pend_d          = (pend_q & ~clr_all) | set_i;
    upd             = (|set_i) | (|clr_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]); // R9
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_q[g]); // R10
  end

  AST_TX_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack_i && !set_i[IDX_TX]) |=> !pend_q[IDX_TX]); // R6
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output logic [NSRC-1:0] sel_o,
  output logic            active_o,
  output logic [3:0]      code_o
);
  logic [NSRC-1:0] live;

  always_comb begin
    live   = pend_i & en_i;
    sel_o  = '0;
    code_o = CODE_NONE;
    if (live[IDX_LN]) begin
      sel_o[IDX_LN] = 1'b1;
      code_o        = CODE_LN;
    end else if (live[IDX_RX]) begin
      sel_o[IDX_RX] = 1'b1;
      code_o        = CODE_RX;
    end else if (live[IDX_TX]) begin
      sel_o[IDX_TX] = 1'b1;
      code_o        = CODE_TX;
    end else if (live[IDX_MD]) begin
      sel_o[IDX_MD] = 1'b1;
      code_o        = CODE_MD;
    end
    active_o = |live;
  end

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(sel_o)); // R1
    AST_SEL_ENABLED: assert ((sel_o & ~en_i) == '0); // R1
  end
endmodule

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
  import sio_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_set,
  input  logic [3:0]        src_clr,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic              id_rd,
  input  logic              out_gate,
  input  logic              fifo_on,
  output logic [3:0]        en_value,
  output logic [DATA_W-1:0] id_value,
  output logic              irq
);
  localparam int unsigned HI_W = 2;
  localparam int unsigned MID_W = DATA_W - HI_W - 4;

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] sel;
  logic            active;
  logic [3:0]      code;
  logic            tx_ack;

  sio_irq_enreg #(.DATA_W(DATA_W)) i_enreg (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .wdata_i(en_wdata), .en_o(en_q)
  );

  sio_irq_flags i_flags (
    .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr),
    .tx_ack_i(tx_ack), .pend_o(pend)
  );

  sio_irq_prio i_prio (
    .pend_i(pend), .en_i(en_q), .sel_o(sel), .active_o(active), .code_o(code)
  );

  assign tx_ack   = id_rd & sel[IDX_TX];
  assign en_value = en_q;
  assign irq      = active & out_gate;
  assign id_value = {{HI_W{fifo_on}}, {MID_W{1'b0}}, code};

  AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (id_value[0] == 1'b0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (id_value[3:0] == CODE_NONE) |-> !irq); // R3
  AST_READ_KEEPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && pend[IDX_TX] && (id_value[3:0] != CODE_TX) && !src_clr[IDX_TX])
      |=> pend[IDX_TX]); // R6
endmodule

// File: tb/test_sio_irq_arbiter.sv
`timescale 1ns/1ps
module test_sio_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_set = '0;
  logic [3:0] src_clr = '0;
  logic       en_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       id_rd = 1'b0;
  logic       out_gate = 1'b0;
  logic       fifo_on = 1'b0;
  logic [3:0] en_value;
  logic [7:0] id_value;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sio_irq_arbiter i_sio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .en_wr(en_wr), .en_wdata(en_wdata), .id_rd(id_rd), .out_gate(out_gate),
    .fifo_on(fifo_on), .en_value(en_value), .id_value(id_value), .irq(irq)
  );

  function automatic logic [3:0] exp_code(input logic [3:0] p, input logic [3:0] e);
    logic [3:0] m;
    m = p & e;
    if (m[2])      return 4'h6;
    else if (m[0]) return 4'h4;
    else if (m[1]) return 4'h2;
    else if (m[3]) return 4'h0;
    return 4'h1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs change at negedge; one posedge registers them; sample at next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    src_set = '0; src_clr = '0; en_wr = 1'b0; id_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    logic [3:0] p;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 enable", {4'h0, en_value}, 8'h00);
    chk("R8 id", id_value, 8'h01);
    chk("R8 irq", {7'h0, irq}, 8'h00);
    out_gate = 1'b1;
    en_wr = 1'b1; en_wdata = 8'hFF; tick();
    chk("R8 flags clear", id_value, 8'h01);
    // R5 upper bits dropped
    chk("R5 F", {4'h0, en_value}, 8'h0F);
    en_wr = 1'b1; en_wdata = 8'hA5; tick();
    chk("R5 A5", {4'h0, en_value}, 8'h05);

    // R1 R2 R3 R4 R7 R10 sweep
    for (int g = 0; g < 2; g++) begin
      for (int ei = 0; ei < 16; ei++) begin
        for (int pi = 0; pi < 16; pi++) begin
          e = ei[3:0]; p = pi[3:0];
          out_gate = g[0];
          src_clr = 4'hF; tick();
          src_set = p; en_wr = 1'b1; en_wdata = {~e, e};
          fifo_on = ei[0] ^ pi[1];
          tick();
          chk("R1 R2 R3 R7 R10 id", id_value,
              {{2{fifo_on}}, 2'b00, exp_code(p, e)});
          chk("R4 irq", {7'h0, irq}, {7'h0, ((p & e) != 0) && g[0]});
        end
      end
    end
    fifo_on = 1'b0; out_gate = 1'b1;

    // R6 read clears transmit-empty when shown
    src_clr = 4'hF; en_wr = 1'b1; en_wdata = 8'h0F; tick();
    src_set = 4'b0010; tick();
    chk("R6 shows tx", id_value, 8'h02);
    id_rd = 1'b1; tick();
    chk("R6 tx cleared", id_value, 8'h01);
    chk("R6 irq low", {7'h0, irq}, 8'h00);
    // R6 read while line hides tx keeps tx
    src_set = 4'b0110; tick();
    chk("R6 line shown", id_value, 8'h06);
    id_rd = 1'b1; tick();
    src_clr = 4'b0100; tick();
    chk("R6 tx kept", id_value, 8'h02);
    // R9 id read and tx set same cycle
    id_rd = 1'b1; src_set = 4'b0010; tick();
    chk("R9 read vs set", id_value, 8'h02);
    // R9 explicit clear and set same cycle
    src_clr = 4'hF; src_set = 4'b0001; tick();
    chk("R9 clr vs set", id_value, 8'h04);
    // R11 masked flag held
    src_clr = 4'hF; en_wr = 1'b1; en_wdata = 8'h00; tick();
    src_set = 4'b1000; tick();
    chk("R11 masked", id_value, 8'h01);
    en_wr = 1'b1; en_wdata = 8'h08; tick();
    chk("R11 unmasked id", id_value, 8'h00);
    chk("R11 unmasked irq", {7'h0, irq}, 8'h01);
    // R4 gate shut
    out_gate = 1'b0; #1;
    chk("R4 gated", {7'h0, irq}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule